// File: doc/BRIEF.md
# Palette Lookup Pixel Unpacker

This block sits between a pixel word FIFO and a display pipeline. It pulls 32-bit words from the FIFO, cuts each word into pixels at a programmed pixel depth, and presents one 16-bit pixel at a time on a valid/ready stream. The first pixel of a word comes from the least significant bits, and each following pixel comes from the next bits up.

In palettized mode, each pixel value is an index into a 256-entry, 16-bit colour table. The table is held as 128 words of 32 bits, with two entries packed in each word, and is loaded through a word-wide write port. In direct mode the pixel value is zero-extended and passed through. The table read is synchronous, so a pixel appears on the stream one cycle after it is taken from the FIFO word. If the sink asks for a pixel while the FIFO is empty, a sticky underflow flag is raised and the previous pixel stays on the output.

Top module: `pix_lut_unpack`

## Requirements
- R1: After reset, `pix_valid`, `pix_data` and `underflow` are all 0, and `fifo_rd` stays 0 while the FIFO is empty.
- R2: Pixels of a word come out in little-endian order. Pixel n of a word is bits [n*B+B-1 : n*B], where B is the pixel depth. `fifo_rd` is high in exactly the cycle the last of the 32/B pixels of the head word is taken, so every word is popped exactly once.
- R3: The `cfg_bpp` encoding is 0=1, 1=2, 2=4, 3=8 and 4=16 bits per pixel. Codes 5 to 7 act as 16 bits per pixel.
- R4: With `cfg_palettized` low, `pix_data` is the raw pixel, zero-extended to 16 bits. At 16 bits per pixel the block always runs in direct mode, whatever `cfg_palettized` is.
- R5: With `cfg_palettized` high and a depth of 1 to 8 bits, `pix_data` is palette entry i, where i is the pixel value. Entry i lives in table word i[7:1]: bits [15:0] when i[0]=0 and bits [31:16] when i[0]=1. A write with `pal_we` high stores `pal_wdata` at word `pal_waddr`.
- R6: A pixel taken from the FIFO head word in one cycle is shown with `pix_valid` high after the next clock edge.
- R7: While `pix_valid` is high and `pix_ready` is low, `pix_valid` and `pix_data` hold their values and nothing is popped.
- R8: If `pix_ready` is high, the output slot is free to take a pixel and the FIFO is empty, `underflow` is set and stays set until reset. If a pixel was shown before, `pix_valid` stays high and the previous `pix_data` is repeated; otherwise `pix_valid` stays low.
- R9: `fifo_rd` is never high while `fifo_empty` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_bpp | input | 3 | Pixel depth code |
| cfg_palettized | input | 1 | 1 = look pixels up in the palette, 0 = direct |
| fifo_empty | input | 1 | The FIFO holds no word |
| fifo_data | input | 32 | Head word of the FIFO (show-ahead) |
| fifo_rd | output | 1 | Pops the head word at the clock edge |
| pal_we | input | 1 | Palette word write strobe |
| pal_waddr | input | 7 | Palette word address |
| pal_wdata | input | 32 | Palette word: odd entry high, even entry low |
| pix_valid | output | 1 | Output pixel is valid |
| pix_ready | input | 1 | Sink accepts the pixel |
| pix_data | output | 16 | Output pixel colour |
| underflow | output | 1 | Sticky flag: a pixel was requested with the FIFO empty |

## Verification
The sweep covers every depth code, including an out-of-range code, in both modes, with two words per run and a sink that stalls in a fixed rhythm. Every pixel is compared with a value computed from the word bits and a palette that is distinct for each entry. A design that reversed the order within a word, picked the wrong halfword from the index low bit, or popped a word one slot early or late would return the wrong colour or leave words in the FIFO. Stall cycles are checked for a changing output, and 16-bit palettized runs catch a lookup that is not bypassed at full depth. Runs end by draining the FIFO, which checks that the last pixel repeats with the flag set. A separate case checks that the flag sets without a valid pixel when no pixel has been shown since reset.

// File: rtl/pix_lut_pkg.sv
package pix_lut_pkg;
   localparam int BPP_CODE_W = 3;

   typedef enum logic [BPP_CODE_W-1:0] {
      DEPTH_1  = 3'd0,
      DEPTH_2  = 3'd1,
      DEPTH_4  = 3'd2,
      DEPTH_8  = 3'd3,
      DEPTH_16 = 3'd4
   } depth_code_e;
endpackage

// File: rtl/pix_word_slicer.sv
module pix_word_slicer #(
   parameter int WORD_W    = 32,
   parameter int PIX_W     = 16,
   parameter int NUM_MODES = 5,
   parameter int MODE_W    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode_idx,
   input  logic              take,
   input  logic              fifo_empty,
   input  logic [WORD_W-1:0] fifo_data,
   output logic [PIX_W-1:0]  pixel,
   output logic              fifo_rd
);
   localparam int SLOT_W = $clog2(WORD_W);

   logic [SLOT_W-1:0] slot_q;
   logic [PIX_W-1:0]  cand    [NUM_MODES];
   logic              is_last [NUM_MODES];

   for (genvar g = 0; g < NUM_MODES; g++) begin : g_mode
      localparam int BW = 1 << g;
      localparam int LAST = WORD_W / BW - 1;
      localparam logic [PIX_W-1:0] MASK = {PIX_W{1'b1}} >> (PIX_W - BW);
      logic [WORD_W-1:0] shamt;
      assign shamt      = WORD_W'(slot_q) << g;
      assign cand[g]    = PIX_W'(fifo_data >> shamt) & MASK;
      assign is_last[g] = (slot_q == SLOT_W'(LAST));
   end

   logic step;
   assign step    = take && !fifo_empty;
   assign pixel   = cand[mode_idx];
   assign fifo_rd = step && is_last[mode_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_q <= '0;
      end else if (step) begin
         slot_q <= is_last[mode_idx] ? '0 : slot_q + 1'b1;
      end
   end
endmodule

// File: rtl/pix_pal_ram.sv
module pix_pal_ram #(
   parameter int WORD_W = 32,
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic              re,
   input  logic [ADDR_W-1:0] raddr,
   output logic [WORD_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [WORD_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  rdata <= '0;
      else if (re) rdata <= mem[raddr];
   end
endmodule

// File: rtl/pix_lut_unpack.sv
module pix_lut_unpack #(
   parameter int WORD_W    = 32,
   parameter int PIX_W     = 16,
   parameter int PAL_DEPTH = 256
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic [pix_lut_pkg::BPP_CODE_W-1:0]     cfg_bpp,
   input  logic                                   cfg_palettized,
   input  logic                                   fifo_empty,
   input  logic [WORD_W-1:0]                      fifo_data,
   output logic                                   fifo_rd,
   input  logic                                   pal_we,
   input  logic [$clog2(PAL_DEPTH)-2:0]           pal_waddr,
   input  logic [WORD_W-1:0]                      pal_wdata,
   output logic                                   pix_valid,
   input  logic                                   pix_ready,
   output logic [PIX_W-1:0]                       pix_data,
   output logic                                   underflow
);
   import pix_lut_pkg::*;

   localparam int IDX_W     = $clog2(PAL_DEPTH);
   localparam int ADDR_W    = IDX_W - 1;
   localparam int NUM_MODES = $clog2(PIX_W) + 1;
   localparam int TOP_MODE  = NUM_MODES - 1;

   if (WORD_W != 2 * PIX_W) begin : g_chk_word
      $error("word must hold exactly two palette entries");
   end
   if ((1 << $clog2(PIX_W)) != PIX_W) begin : g_chk_pix
      $error("pixel width must be a power of two");
   end
   if ((1 << IDX_W) != PAL_DEPTH || PIX_W / 2 > IDX_W) begin : g_chk_pal
      $error("palette depth must be a power of two covering every lookup depth");
   end
   if (TOP_MODE > (1 << BPP_CODE_W) - 1) begin : g_chk_code
      $error("depth code too narrow");
   end

   logic [BPP_CODE_W-1:0] mode_idx;
   assign mode_idx = (cfg_bpp > BPP_CODE_W'(TOP_MODE)) ? BPP_CODE_W'(TOP_MODE) : cfg_bpp;

   logic pal_mode;
   assign pal_mode = cfg_palettized && (mode_idx != BPP_CODE_W'(TOP_MODE));

   logic             valid_q, seen_q, uflow_q, lut_q, sel_q;
   logic [PIX_W-1:0] direct_q;
   logic             adv, load, uf_event;
   logic [PIX_W-1:0] pixel;
   logic [WORD_W-1:0] pal_rdata;

   assign adv      = !valid_q || pix_ready;
   assign load     = adv && !fifo_empty;
   assign uf_event = adv && fifo_empty && pix_ready;

   pix_word_slicer #(
      .WORD_W   (WORD_W),
      .PIX_W    (PIX_W),
      .NUM_MODES(NUM_MODES),
      .MODE_W   (BPP_CODE_W)
   ) u_slicer (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_idx  (mode_idx),
      .take      (adv),
      .fifo_empty(fifo_empty),
      .fifo_data (fifo_data),
      .pixel     (pixel),
      .fifo_rd   (fifo_rd)
   );

   pix_pal_ram #(
      .WORD_W(WORD_W),
      .ADDR_W(ADDR_W)
   ) u_pal (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (pal_we),
      .waddr(pal_waddr),
      .wdata(pal_wdata),
      .re   (load && pal_mode),
      .raddr(pixel[IDX_W-1:1]),
      .rdata(pal_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q  <= 1'b0;
         seen_q   <= 1'b0;
         uflow_q  <= 1'b0;
         lut_q    <= 1'b0;
         sel_q    <= 1'b0;
         direct_q <= '0;
      end else begin
         if (load) begin
            valid_q  <= 1'b1;
            seen_q   <= 1'b1;
            lut_q    <= pal_mode;
            sel_q    <= pixel[0];
            direct_q <= pixel;
         end else if (uf_event) begin
            valid_q  <= seen_q;
         end else if (adv) begin
            valid_q  <= 1'b0;
         end
         if (uf_event) uflow_q <= 1'b1;
      end
   end

   assign pix_valid = valid_q;
   assign underflow = uflow_q;
   assign pix_data  = lut_q ? (sel_q ? pal_rdata[WORD_W-1:PIX_W] : pal_rdata[PIX_W-1:0])
                            : direct_q;
endmodule

// File: rtl/pix_lut_unpack_chk.sv
module pix_lut_unpack_chk #(
   parameter int PIX_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             fifo_empty,
   input logic             fifo_rd,
   input logic             pix_valid,
   input logic             pix_ready,
   input logic [PIX_W-1:0] pix_data,
   input logic             underflow
);
   assert_pop_shows_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_rd |=> pix_valid);

   assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_data)));

   assert_stall_no_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && !pix_ready) |-> !fifo_rd);

   assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      underflow |=> underflow);

   assert_starve_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_ready && fifo_empty) |=> underflow);

   assert_no_pop_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_empty |-> !fifo_rd);
endmodule

bind pix_lut_unpack pix_lut_unpack_chk #(.PIX_W(PIX_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .fifo_empty(fifo_empty),
   .fifo_rd   (fifo_rd),
   .pix_valid (pix_valid),
   .pix_ready (pix_ready),
   .pix_data  (pix_data),
   .underflow (underflow)
);

// File: tb/pix_lut_unpack_test.sv
module pix_lut_unpack_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  cfg_bpp = '0;
   logic        cfg_palettized = 1'b0;
   logic        fifo_empty;
   logic [31:0] fifo_data;
   logic        fifo_rd;
   logic        pal_we = 1'b0;
   logic [6:0]  pal_waddr = '0;
   logic [31:0] pal_wdata = '0;
   logic        pix_valid;
   logic        pix_ready = 1'b0;
   logic [15:0] pix_data;
   logic        underflow;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   logic [31:0] fq [16];
   int unsigned wr_ptr = 0;
   int unsigned rd_ptr = 0;
   assign fifo_empty = (wr_ptr == rd_ptr);
   assign fifo_data  = fq[rd_ptr[3:0]];
   always @(posedge clk) if (fifo_rd) rd_ptr <= rd_ptr + 1;

   pix_lut_unpack uut (
      .clk(clk), .rst_n(rst_n), .cfg_bpp(cfg_bpp), .cfg_palettized(cfg_palettized),
      .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_rd(fifo_rd),
      .pal_we(pal_we), .pal_waddr(pal_waddr), .pal_wdata(pal_wdata),
      .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
      .underflow(underflow)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   function automatic logic [15:0] pal_entry(input int i, input int seed);
      logic [7:0] a, b;
      a = 8'(i) ^ 8'h5A ^ 8'(seed * 29);
      b = ~8'(i) + 8'(seed);
      return {a, b};
   endfunction

   function automatic logic [31:0] word_of(input int k, input int seed);
      return 32'hA5C3_0F96 ^ (32'(k + 1) * 32'h1357_9BDF) ^ (32'(seed) << 11);
   endfunction

   task automatic do_reset();
      rst_n = 1'b0;
      pix_ready = 1'b0;
      repeat (2) @(negedge clk);
      wr_ptr = rd_ptr;
      rst_n = 1'b1;
      @(negedge clk);
      chk(pix_valid == 1'b0, "R1 valid", 32'(pix_valid), 0);
      chk(pix_data == 16'h0, "R1 data", 32'(pix_data), 0);
      chk(underflow == 1'b0, "R1 flag", 32'(underflow), 0);
      chk(fifo_rd == 1'b0, "R1 pop", 32'(fifo_rd), 0);
   endtask

   task automatic push(input logic [31:0] w);
      fq[wr_ptr[3:0]] = w;
      wr_ptr = wr_ptr + 1;
   endtask

   task automatic run_cfg(input int code, input bit pal);
      logic [15:0] exp_q [64];
      int eb, bw, per, n, seed, k, cyc;
      bit prev_stall;
      logic [15:0] prev_data;
      unsigned_base: begin end
      seed = code * 2 + int'(pal) + 1;
      eb = (code > 4) ? 4 : code;
      bw = 1 << eb;
      per = 32 / bw;
      n = 2 * per;
      do_reset();
      cfg_bpp = 3'(code);
      cfg_palettized = pal;
      for (int w = 0; w < 128; w++) begin
         pal_we = 1'b1;
         pal_waddr = 7'(w);
         pal_wdata = {pal_entry(2 * w + 1, seed), pal_entry(2 * w, seed)};
         @(negedge clk);
      end
      pal_we = 1'b0;
      for (int j = 0; j < n; j++) begin
         logic [31:0] wd, raw;
         wd = word_of(j / per, seed);
         raw = (wd >> ((j % per) * bw)) & ((33'h1 << bw) - 1);
         exp_q[j] = (pal && eb < 4) ? pal_entry(int'(raw[7:0]), seed) : raw[15:0];
      end
      chk(pix_valid == 1'b0, "R6 idle before data", 32'(pix_valid), 0);
      push(word_of(0, seed));
      @(negedge clk);
      chk(pix_valid == 1'b1, "R6 one cycle latency", 32'(pix_valid), 1);
      chk(pix_data == exp_q[0], (pal && eb < 4) ? "R5 first lookup" : "R4 first direct",
          32'(pix_data), 32'(exp_q[0]));
      push(word_of(1, seed));
      k = 0;
      cyc = 0;
      prev_stall = 1'b0;
      prev_data = '0;
      while (k < n && cyc < 2000) begin
         pix_ready = (cyc % 3 != 1);
         if (prev_stall) begin
            chk(pix_valid == 1'b1, "R7 valid held", 32'(pix_valid), 1);
            chk(pix_data == prev_data, "R7 data held", 32'(pix_data), 32'(prev_data));
         end
         if (pix_valid && pix_ready) begin
            chk(pix_data == exp_q[k],
                (pal && eb < 4) ? "R5/R2/R3 palette pixel" : "R4/R2/R3 direct pixel",
                32'(pix_data), 32'(exp_q[k]));
            k++;
         end
         prev_stall = pix_valid && !pix_ready;
         prev_data = pix_data;
         @(negedge clk);
         cyc++;
      end
      pix_ready = 1'b1;
      chk(k == n, "R2 pixel count", 32'(k), 32'(n));
      repeat (2) @(negedge clk);
      chk(rd_ptr == wr_ptr, "R2 words popped", rd_ptr, wr_ptr);
      chk(underflow == 1'b1, "R8 flag after drain", 32'(underflow), 1);
      chk(pix_valid == 1'b1, "R8 repeat valid", 32'(pix_valid), 1);
      chk(pix_data == exp_q[n-1], "R8 repeat last", 32'(pix_data), 32'(exp_q[n-1]));
      chk(fifo_rd == 1'b0, "R9 no pop when empty", 32'(fifo_rd), 0);
      pix_ready = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      for (int code = 0; code < 6; code++) begin
         for (int p = 0; p < 2; p++) begin
            run_cfg(code, p[0]);
         end
      end
      // R8: starving with no earlier pixel
      do_reset();
      cfg_bpp = 3'd3;
      cfg_palettized = 1'b0;
      pix_ready = 1'b1;
      repeat (2) @(negedge clk);
      chk(underflow == 1'b1, "R8 flag without pixel", 32'(underflow), 1);
      chk(pix_valid == 1'b0, "R8 no valid without pixel", 32'(pix_valid), 0);
      push(32'h0403_0201);
      @(negedge clk);
      chk(pix_valid == 1'b1, "R6 valid after late word", 32'(pix_valid), 1);
      chk(pix_data == 16'h0001, "R2 low byte first", 32'(pix_data), 32'h1);
      chk(underflow == 1'b1, "R8 flag sticky", 32'(underflow), 1);
      pix_ready = 1'b0;
      summary();
   end
endmodule